// File: doc/BRIEF.md
# Message Start, Busy and Standby Sequencer

This controller sits at the top of a message player. A host starts a message with an active-low strobe qualified by an active-low chip select. In stand-alone mode the strobe is the start line and the 8-bit message code is latched on its trailing (rising) edge. In slave mode the write line is the strobe and no code is latched. After a fixed delay the controller pulls an active-low busy line and enables the downstream ROM fetch and decoder blocks. When the decoder reports that the message is finished, busy is released.

After a message ends, the controller holds the output at mid-scale for a long idle window. It then ramps the 9-bit DAC code slowly from mid-scale down to zero and enters standby. In standby the busy driver is released, which is modelled by an output enable. A start that arrives in standby ramps the DAC back up to mid-scale and waits a warm-up interval before playback. A start during the idle window skips both ramp and warm-up. A start during the downward ramp reverses the ramp from the level it has reached.

All delays are parameters counted in clocks of the 640 kHz system clock. The ADPCM arithmetic and the analog converter are outside this block. While the controller owns the DAC it asserts `dac_ovr`. During playback the decoder drives the DAC instead.

Top module: `msg_seq_ctl`

## Requirements
- R1: A start is accepted only when `cs_n` is 0 and the selected strobe is seen falling while the controller is idle, ramping down or in standby. `busy_n` goes to 0 exactly `BUSY_DLY` clocks after the first clock edge that samples the strobe low. With `cs_n` at 1, no start occurs.
- R2: In stand-alone mode (`slave_q`=0), `msg_code` loads `code_in` at the first rising edge of `st_n` after an accepted start, and it holds that value otherwise.
- R3: While `busy_n` is 0, falling edges on `st_n` and `wr_n` start nothing, `msg_code` does not change, and `mode_sel` is not taken. `slave_q` follows `mode_sel` only in the idle window after a message or after reset.
- R4: In slave mode (`slave_q`=1), a falling `wr_n` with `cs_n` at 0 starts a message, `st_n` is ignored, and `msg_code` is left unchanged.
- R5: If `synth_done` is sampled at 1 during playback, `busy_n` is 1 and `fetch_en` and `dec_en` are 0 from the next clock.
- R6: `HOLD_CYC` clocks after the end of a message, `dac_code` falls from 100h by one code every `RAMP_DIV` clocks. One clock after it reaches 000h, `busy_oe` goes to 0 (standby). In standby, `busy_n` is 1 and `dac_code` is 000h.
- R7: A start in standby gives `busy_n` 0 after `BUSY_DLY` clocks. `dac_code` then rises by one code every `RAMP_DIV` clocks up to 100h. `fetch_en` rises one clock after 100h is reached, and `dec_en` rises `WARM_CYC` clocks after that.
- R8: A start during the idle window sets `busy_n` to 0 and `dec_en` to 1 in the same clock, `BUSY_DLY` clocks after the strobe, with no ramp and no warm-up.
- R9: A start during the downward ramp freezes `dac_code` at its current level until busy falls. The ramp then rises from that level to 100h, followed by the warm-up.
- R10: `dac_ovr` is 1 in every state except playback. While it is 1, `dac_code` never exceeds 100h and changes by at most one code per clock. `dec_en` implies `fetch_en`.
- R11: Synchronous reset (`rst`=1) gives `busy_n`=1, `busy_oe`=1, `dac_code`=100h, `dac_ovr`=1, `fetch_en`=`dec_en`=0, `msg_code`=00h and `slave_q`=0. The idle window then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| st_n | input | 1 | Start strobe for stand-alone mode, active low |
| wr_n | input | 1 | Write strobe for slave mode, active low |
| mode_sel | input | 1 | Requested mode: 1 = slave, 0 = stand-alone |
| code_in | input | 8 | Message code from the host |
| synth_done | input | 1 | Decoder reports the end of the message |
| busy_n | output | 1 | Busy, active low |
| busy_oe | output | 1 | Busy driver enable; 0 in standby |
| msg_code | output | 8 | Latched message code |
| slave_q | output | 1 | Accepted operating mode |
| dac_code | output | 9 | DAC code while the controller owns the DAC |
| dac_ovr | output | 1 | Controller owns the DAC |
| fetch_en | output | 1 | Enable for the ROM fetch block |
| dec_en | output | 1 | Enable for the decoder |

## Verification
The hardest case to reach from the ports is a start that lands in the middle of the downward ramp, because it needs the exact ramp level at the moment of the strobe. The bench gets there by counting clocks from the end of a message through the idle window into the ramp. It issues the start at a clock where the expected level is known arithmetically. It then checks that the level stays frozen through the busy delay and climbs back on the predicted schedule. Full ramp sweeps in both directions compare every clock against a floor division of the elapsed count.

// File: rtl/msg_seq_pkg.sv
package msg_seq_pkg;

    localparam int          DAC_W    = 9;
    localparam logic [8:0]  DAC_ZERO = 9'h000;
    localparam logic [8:0]  DAC_MID  = 9'h100;

    typedef enum logic [2:0] {
        S_IDLE,   // operation mode, waiting out the hold window
        S_DOWN,   // ramping mid-scale to zero
        S_SLEEP,  // standby
        S_ARM,    // start accepted, busy not yet asserted
        S_UP,     // ramping zero to mid-scale
        S_WARM,   // DAC at mid-scale, settling before playback
        S_PLAY    // decoder running
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic oe;
        logic ovr;
        logic fetch;
        logic dec;
    } seq_out_s;

    function automatic seq_out_s decode_out(seq_state_e s);
        seq_out_s o;
        o.busy  = (s == S_UP) || (s == S_WARM) || (s == S_PLAY);
        o.oe    = (s != S_SLEEP);
        o.ovr   = (s != S_PLAY);
        o.fetch = (s == S_WARM) || (s == S_PLAY);
        o.dec   = (s == S_PLAY);
        return o;
    endfunction

    function automatic logic takes_start(seq_state_e s);
        return (s == S_IDLE) || (s == S_DOWN) || (s == S_SLEEP);
    endfunction

endpackage

// File: rtl/msg_seq_edge.sv
module msg_seq_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_n,
    output logic fall,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sig_n;
    end

    assign fall = prev_q & ~sig_n;
    assign rise = ~prev_q & sig_n;
endmodule

// File: rtl/msg_seq_timer.sv
module msg_seq_timer #(
    parameter int WIDTH = 8,
    parameter int INIT  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= WIDTH'(INIT);
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/msg_seq_ramp.sv
module msg_seq_ramp import msg_seq_pkg::*; #(
    parameter int DIV = 117
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             up,
    output logic [DAC_W-1:0] code,
    output logic             at_mid,
    output logic             at_zero
);
    localparam int DW = $clog2(DIV + 1);

    logic [DW-1:0] div_q;
    logic          step;

    assign step    = run && (div_q == DW'(DIV - 1));
    assign at_mid  = (code == DAC_MID);
    assign at_zero = (code == DAC_ZERO);

    always_ff @(posedge clk) begin
        if (rst || !run || step) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= DAC_MID;
        end else if (step) begin
            if (up && !at_mid)        code <= code + 1'b1;
            else if (!up && !at_zero) code <= code - 1'b1;
        end
    end
endmodule

// File: rtl/msg_seq_ctl.sv
module msg_seq_ctl import msg_seq_pkg::*; #(
    parameter int BUSY_DLY = 5,
    parameter int RAMP_DIV = 117,
    parameter int WARM_CYC = 1344,
    parameter int HOLD_CYC = 1920000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             st_n,
    input  logic             wr_n,
    input  logic             mode_sel,
    input  logic [7:0]       code_in,
    input  logic             synth_done,
    output logic             busy_n,
    output logic             busy_oe,
    output logic [7:0]       msg_code,
    output logic             slave_q,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_ovr,
    output logic             fetch_en,
    output logic             dec_en
);
    localparam int TW = $clog2(HOLD_CYC + WARM_CYC + BUSY_DLY) + 1;

    seq_state_e state_q, state_d;
    seq_out_s   outs;

    logic st_fall, st_rise, wr_fall, wr_rise;
    logic sel_fall, sel_rise, start;
    logic from_sleep_q, cap_arm_q;
    logic tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic ramp_run, ramp_up, at_mid, at_zero;

    msg_seq_edge u_st_edge (.clk(clk), .rst(rst), .sig_n(st_n), .fall(st_fall), .rise(st_rise));
    msg_seq_edge u_wr_edge (.clk(clk), .rst(rst), .sig_n(wr_n), .fall(wr_fall), .rise(wr_rise));

    msg_seq_timer #(.WIDTH(TW), .INIT(HOLD_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    msg_seq_ramp #(.DIV(RAMP_DIV)) u_ramp (
        .clk(clk), .rst(rst), .run(ramp_run), .up(ramp_up),
        .code(dac_code), .at_mid(at_mid), .at_zero(at_zero)
    );

    assign sel_fall = slave_q ? wr_fall : st_fall;
    assign sel_rise = slave_q ? wr_rise : st_rise;
    assign start    = !cs_n && sel_fall && takes_start(state_q);

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ramp_run = 1'b0;
        ramp_up  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d  = S_ARM;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(BUSY_DLY - 1);
                end else if (tmr_zero) begin
                    state_d = S_DOWN;
                end
            end
            S_DOWN: begin
                ramp_run = 1'b1;
                if (start) begin
                    state_d  = S_ARM;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(BUSY_DLY - 1);
                end else if (at_zero) begin
                    state_d = S_SLEEP;
                end
            end
            S_SLEEP: begin
                if (start) begin
                    state_d  = S_ARM;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(BUSY_DLY - 1);
                end
            end
            S_ARM: begin
                if (tmr_zero) state_d = from_sleep_q ? S_UP : S_PLAY;
            end
            S_UP: begin
                ramp_run = 1'b1;
                ramp_up  = 1'b1;
                if (at_mid) begin
                    state_d  = S_WARM;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(WARM_CYC - 1);
                end
            end
            S_WARM: begin
                if (tmr_zero) state_d = S_PLAY;
            end
            S_PLAY: begin
                if (synth_done) begin
                    state_d  = S_IDLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            from_sleep_q <= 1'b0;
            cap_arm_q    <= 1'b0;
            msg_code     <= '0;
            slave_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                from_sleep_q <= (state_q != S_IDLE);
                cap_arm_q    <= 1'b1;
            end else if (sel_rise) begin
                cap_arm_q <= 1'b0;
            end
            if (cap_arm_q && sel_rise && !slave_q) msg_code <= code_in;
            if (state_q == S_IDLE) slave_q <= mode_sel;
        end
    end

    assign outs     = decode_out(state_q);
    assign busy_n   = ~outs.busy;
    assign busy_oe  = outs.oe;
    assign dac_ovr  = outs.ovr;
    assign fetch_en = outs.fetch;
    assign dec_en   = outs.dec;
endmodule

// File: rtl/msg_seq_ctl_chk.sv
module msg_seq_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_n,
    input logic       busy_oe,
    input logic [8:0] dac_code,
    input logic       dac_ovr,
    input logic       fetch_en,
    input logic       dec_en,
    input logic       slave_q
);
    a_r10_dac_cap: assert property (@(posedge clk) disable iff (rst)
        dac_ovr |-> (dac_code <= 9'h100));

    a_r10_dac_slew: assert property (@(posedge clk) disable iff (rst)
        (dac_ovr && $past(dac_ovr)) |->
            ((dac_code == $past(dac_code)) ||
             (dac_code == $past(dac_code) + 9'd1) ||
             (dac_code + 9'd1 == $past(dac_code))));

    a_r10_dec_fetch: assert property (@(posedge clk) disable iff (rst)
        dec_en |-> (fetch_en && !busy_n && !dac_ovr));

    a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_oe |-> (busy_n && dac_code == 9'h000 && dac_ovr && !fetch_en));

    a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !busy_n |=> $stable(slave_q));

    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n) |-> (!dec_en && !fetch_en));
endmodule

bind msg_seq_ctl msg_seq_ctl_chk u_chk (
    .clk(clk), .rst(rst), .busy_n(busy_n), .busy_oe(busy_oe),
    .dac_code(dac_code), .dac_ovr(dac_ovr), .fetch_en(fetch_en),
    .dec_en(dec_en), .slave_q(slave_q)
);

// File: tb/msg_seq_ctl_bench.sv
module msg_seq_ctl_bench;
    localparam int D = 5;
    localparam int R = 3;
    localparam int W = 20;
    localparam int H = 50;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1, cs_n = 1'b1, st_n = 1'b1, wr_n = 1'b1, mode_sel = 1'b0, synth_done = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic       busy_n, busy_oe, slave_q, dac_ovr, fetch_en, dec_en;
    logic [7:0] msg_code;
    logic [8:0] dac_code;

    msg_seq_ctl #(.BUSY_DLY(D), .RAMP_DIV(R), .WARM_CYC(W), .HOLD_CYC(H)) u_msg_seq_ctl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .st_n(st_n), .wr_n(wr_n), .mode_sel(mode_sel),
        .code_in(code_in), .synth_done(synth_done), .busy_n(busy_n), .busy_oe(busy_oe),
        .msg_code(msg_code), .slave_q(slave_q), .dac_code(dac_code), .dac_ovr(dac_ovr),
        .fetch_en(fetch_en), .dec_en(dec_en)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic fire(bit use_wr, bit cs_high, logic [7:0] c, bit go, bit direct);
        code_in = c;
        cs_n = cs_high;
        if (use_wr) wr_n = 1'b0; else st_n = 1'b0;
        tick();
        st_n = 1'b1;
        wr_n = 1'b1;
        repeat (D - 1) tick();
        chk("R1 busy held before delay", busy_n, 1);
        tick();
        chk("R1 busy after delay", busy_n, go ? 0 : 1);
        if (go && direct) chk("R8 playback without ramp", dec_en, 1);
        cs_n = 1'b1;
    endtask

    task automatic end_msg();
        synth_done = 1'b1;
        tick();
        synth_done = 1'b0;
        chk("R5 busy released", busy_n, 1);
        chk("R5 decoder off", dec_en, 0);
        chk("R5 fetch off", fetch_en, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) tick();
        chk("R11 busy_n", busy_n, 1);
        chk("R11 busy_oe", busy_oe, 1);
        chk("R11 dac_code", dac_code, 256);
        chk("R11 dac_ovr", dac_ovr, 1);
        chk("R11 enables", {fetch_en, dec_en}, 0);
        chk("R11 msg_code", msg_code, 0);
        chk("R11 slave_q", slave_q, 0);
        rst = 1'b0;
        tick();

        // R1: chip select high blocks the start
        fire(1'b0, 1'b1, 8'h11, 1'b0, 1'b0);
        chk("R1 no capture with cs high", msg_code, 0);

        // R8 + R2: start from the idle window
        fire(1'b0, 1'b0, 8'hA5, 1'b1, 1'b1);
        chk("R2 code latched", msg_code, 8'hA5);
        chk("R10 fetch with decoder", fetch_en, 1);
        chk("R10 ovr released", dac_ovr, 0);

        // R3: strobes and mode change while busy
        code_in = 8'h3C; cs_n = 1'b0; st_n = 1'b0; wr_n = 1'b0; mode_sel = 1'b1;
        tick(); tick();
        st_n = 1'b1; wr_n = 1'b1;
        tick(); tick();
        cs_n = 1'b1;
        chk("R3 code unchanged while busy", msg_code, 8'hA5);
        chk("R3 mode not taken while busy", slave_q, 0);
        chk("R3 still playing", dec_en, 1);

        end_msg();
        tick();
        chk("R3 mode taken in idle", slave_q, 1);

        // R4: slave mode
        fire(1'b0, 1'b0, 8'h77, 1'b0, 1'b0);
        chk("R4 st ignored in slave", msg_code, 8'hA5);
        fire(1'b1, 1'b0, 8'h99, 1'b1, 1'b1);
        chk("R4 slave start keeps code", msg_code, 8'hA5);
        mode_sel = 1'b0;
        tick();
        chk("R3 mode held while busy", slave_q, 1);

        // R6: idle window, down ramp, standby
        end_msg();
        for (int k = 1; k <= H + 256 * R + 1; k++) begin
            int e;
            tick();
            if (k == 1) chk("R3 mode back in idle", slave_q, 0);
            e = (k <= H) ? 256 : 256 - (((k - H) / R) > 256 ? 256 : (k - H) / R);
            chk("R6 down ramp level", dac_code, e);
            chk("R6 standby entry", busy_oe, (k < H + 256 * R + 1) ? 1 : 0);
        end
        chk("R6 standby busy_n", busy_n, 1);

        // R7: wake from standby
        fire(1'b0, 1'b0, 8'h5A, 1'b1, 1'b0);
        chk("R7 dac at zero at busy", dac_code, 0);
        chk("R2 wake code", msg_code, 8'h5A);
        for (int k = 1; k <= 256 * R + W + 1; k++) begin
            tick();
            chk("R7 up ramp level", dac_code, (k / R > 256) ? 256 : k / R);
            chk("R7 fetch timing", fetch_en, (k >= 256 * R + 1) ? 1 : 0);
            chk("R7 decoder timing", dec_en, (k == 256 * R + W + 1) ? 1 : 0);
            chk("R7 busy during wake", busy_n, 0);
        end

        // R9: start in the middle of the down ramp
        end_msg();
        repeat (H + 30) tick();
        chk("R6 mid ramp level", dac_code, 246);
        fire(1'b0, 1'b0, 8'hC3, 1'b1, 1'b0);
        chk("R9 level frozen", dac_code, 246);
        chk("R9 code latched", msg_code, 8'hC3);
        for (int k = 1; k <= 10 * R + W + 1; k++) begin
            tick();
            chk("R9 reversed ramp", dac_code, (246 + k / R > 256) ? 256 : 246 + k / R);
            chk("R9 decoder timing", dec_en, (k == 10 * R + W + 1) ? 1 : 0);
        end
        end_msg();

        summary();
        $finish;
    end
endmodule